// File: doc/BRIEF.md
# Fixed-Point YCbCr to RGB Converter

This block turns a stream of full-rate 8-bit luma/chroma pixels into 8-bit red, green and blue values ready for a VGA-style display path. One pixel can enter on every clock. Floating-point arithmetic is avoided: each fractional colour-matrix weight is stored as an integer pre-multiplied by a power of two (1024), and each weighted sum is brought back to pixel scale by an arithmetic right shift of 10 bits.

The datapath has three registered stages. Stage one removes the video offsets (16 from luma, 128 from each chroma component) and produces signed 9-bit differences. Stage two forms the five constant products. Stage three adds the products per channel, shifts, clamps to 0..255 and forces black when the blanking flag is set. A valid bit and the horizontal sync, vertical sync and blanking flags travel through a matching three-stage delay, so every output pixel leaves aligned with its own flags.

Top module: `ycc2rgb_conv`

## Requirements
- R1: With its input in range, red equals floor((1192·(Y−16) + 1634·(Cr−128)) / 1024), computed with an arithmetic shift.
- R2: Green equals floor((1192·(Y−16) − 833·(Cr−128) − 401·(Cb−128)) / 1024) when that lies in 0..255.
- R3: Blue equals floor((1192·(Y−16) + 2065·(Cb−128)) / 1024) when that lies in 0..255.
- R4: A channel whose shifted sum is negative outputs 0 (for example Y=0, Cb=Cr=128 gives R=G=B=0).
- R5: A channel whose shifted sum exceeds 255 outputs 255 (for example Y=255, Cb=Cr=128 gives R=G=B=255).
- R6: out_valid equals in_valid as sampled three rising edges earlier, and the RGB values belong to that same input pixel.
- R7: out_hsync and out_vsync equal in_hsync and in_vsync as sampled three rising edges earlier.
- R8: Whenever out_blank is 1, out_r, out_g and out_b are all 0.
- R9: On a rising edge with rst high, out_valid, out_hsync, out_vsync and out_blank become 0, and pixels held in the pipeline at that edge never emerge.
- R10: Back-to-back pixels on consecutive cycles each produce their own result on consecutive cycles; a cycle with in_valid low yields a cycle with out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| in_hsync | input | 1 | Horizontal sync, passed through |
| in_vsync | input | 1 | Vertical sync, passed through |
| in_blank | input | 1 | Blanking flag, passed through |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_blank | output | 1 | Delayed blanking flag |

## Verification
The bench builds the converter with its default parameters: 8-bit pixels, a 10-bit fraction and the five integer weights 1192, 1634, 833, 401 and 2065. With these values luma 0 and 255 drive every channel past both clamp limits, saturated chroma pushes single channels past them while the others stay in range, and mid-range pixels exercise the floor behaviour of the shift on negative and positive partial sums. Streaming the table back to back with a bubble, flag toggles and a blanked pixel places the three-cycle alignment of data and flags, and a reset issued while pixels are in flight, within reach.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    // Flags that travel alongside each pixel through the pipeline.
    typedef struct packed {
        logic valid;
        logic hsync;
        logic vsync;
        logic blank;
    } pix_flags_t;

    localparam pix_flags_t FLAGS_IDLE = '{valid: 1'b0, hsync: 1'b0, vsync: 1'b0, blank: 1'b0};

    // Number of products formed by the multiply stage.
    localparam int NUM_PROD = 5;
    // Product slots, in the order the multiply stage produces them.
    localparam int P_Y  = 0;
    localparam int P_RV = 1;
    localparam int P_GV = 2;
    localparam int P_GU = 3;
    localparam int P_BU = 4;

    // Number of colour channels and terms summed per channel.
    localparam int NUM_CH    = 3;
    localparam int TERMS_PER = 3;

endpackage

// File: rtl/ycc_flag_pipe.sv
module ycc_flag_pipe
    import ycc_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  pix_flags_t flags_i,
    output pix_flags_t taps_o [DEPTH]
);

    pix_flags_t stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= FLAGS_IDLE;
                    else     stage_q[s] <= flags_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= FLAGS_IDLE;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
            assign taps_o[s] = stage_q[s];
        end
    endgenerate

endmodule

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage #(
    parameter int PIX_W = 8,
    parameter int Y_OFS = 16,
    parameter int C_OFS = 128,
    localparam int OFS_W = PIX_W + 1
) (
    input  logic                    clk,
    input  logic [PIX_W-1:0]        y_i,
    input  logic [PIX_W-1:0]        cb_i,
    input  logic [PIX_W-1:0]        cr_i,
    output logic signed [OFS_W-1:0] dy_o,
    output logic signed [OFS_W-1:0] dcb_o,
    output logic signed [OFS_W-1:0] dcr_o
);

    localparam logic signed [OFS_W-1:0] Y_BASE = OFS_W'(Y_OFS);
    localparam logic signed [OFS_W-1:0] C_BASE = OFS_W'(C_OFS);

    logic signed [OFS_W-1:0] dy_c, dcb_c, dcr_c;

    always_comb begin
        dy_c  = $signed({1'b0, y_i})  - Y_BASE;
        dcb_c = $signed({1'b0, cb_i}) - C_BASE;
        dcr_c = $signed({1'b0, cr_i}) - C_BASE;
    end

    always_ff @(posedge clk) begin
        dy_o  <= dy_c;
        dcb_o <= dcb_c;
        dcr_o <= dcr_c;
    end

endmodule

// File: rtl/ycc_mult_stage.sv
module ycc_mult_stage
    import ycc_pkg::*;
#(
    parameter int OFS_W  = 9,
    parameter int COEF_W = 13,
    parameter int COEFS [NUM_PROD] = '{1192, 1634, 833, 401, 2065},
    localparam int PROD_W = OFS_W + COEF_W
) (
    input  logic                     clk,
    input  logic signed [OFS_W-1:0]  dy_i,
    input  logic signed [OFS_W-1:0]  dcb_i,
    input  logic signed [OFS_W-1:0]  dcr_i,
    output logic signed [PROD_W-1:0] prod_o [NUM_PROD]
);

    // Operand routing: luma for slot 0, red chroma for slots 1-2, blue chroma for 3-4.
    logic signed [OFS_W-1:0] operand [NUM_PROD];

    always_comb begin
        operand[P_Y]  = dy_i;
        operand[P_RV] = dcr_i;
        operand[P_GV] = dcr_i;
        operand[P_GU] = dcb_i;
        operand[P_BU] = dcb_i;
    end

    generate
        for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
            localparam logic signed [PROD_W-1:0] KWIDE = PROD_W'(COEFS[p]);
            logic signed [PROD_W-1:0] op_wide;
            logic signed [PROD_W-1:0] prod_c;

            assign op_wide = {{(PROD_W-OFS_W){operand[p][OFS_W-1]}}, operand[p]};
            assign prod_c  = op_wide * KWIDE;

            always_ff @(posedge clk) begin
                prod_o[p] <= prod_c;
            end
        end
    endgenerate

endmodule

// File: rtl/ycc_chan_out.sv
module ycc_chan_out
    import ycc_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int FRAC_BITS = 10,
    parameter int PIX_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] term_i [TERMS_PER],
    input  logic                    blank_i,
    output logic [PIX_W-1:0]        pix_o
);

    localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] sum_c;
    logic signed [ACC_W-1:0] scaled_c;
    logic [PIX_W-1:0]        clamp_c;

    always_comb begin
        sum_c = '0;
        for (int t = 0; t < TERMS_PER; t++) begin
            sum_c = sum_c + term_i[t];
        end
        scaled_c = sum_c >>> FRAC_BITS;
        if (scaled_c < 0)
            clamp_c = '0;
        else if (scaled_c > PIX_MAX)
            clamp_c = '1;
        else
            clamp_c = scaled_c[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          pix_o <= '0;
        else if (blank_i) pix_o <= '0;
        else              pix_o <= clamp_c;
    end

endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
    import ycc_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int FRAC_BITS = 10,
    parameter int Y_OFS     = 16,
    parameter int C_OFS     = 128,
    parameter int COEF_W    = 13,
    parameter int K_Y       = 1192,
    parameter int K_RV      = 1634,
    parameter int K_GV      = 833,
    parameter int K_GU      = 401,
    parameter int K_BU      = 2065
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0] in_cb,
    input  logic [PIX_W-1:0] in_cr,
    input  logic             in_hsync,
    input  logic             in_vsync,
    input  logic             in_blank,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_r,
    output logic [PIX_W-1:0] out_g,
    output logic [PIX_W-1:0] out_b,
    output logic             out_hsync,
    output logic             out_vsync,
    output logic             out_blank
);

    localparam int OFS_W   = PIX_W + 1;
    localparam int PROD_W  = OFS_W + COEF_W;
    localparam int ACC_W   = PROD_W + 2;
    localparam int LATENCY = 3;
    localparam int COEF_SET [NUM_PROD] = '{K_Y, K_RV, K_GV, K_GU, K_BU};

    // Flag delay line, one tap per datapath stage.
    pix_flags_t flags_in;
    pix_flags_t flag_tap [LATENCY];

    assign flags_in = '{valid: in_valid, hsync: in_hsync, vsync: in_vsync, blank: in_blank};

    ycc_flag_pipe #(.DEPTH(LATENCY)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .flags_i(flags_in),
        .taps_o (flag_tap)
    );

    // Stage 1: offset removal.
    logic signed [OFS_W-1:0] dy_q, dcb_q, dcr_q;

    ycc_offset_stage #(
        .PIX_W(PIX_W),
        .Y_OFS(Y_OFS),
        .C_OFS(C_OFS)
    ) u_offset (
        .clk  (clk),
        .y_i  (in_y),
        .cb_i (in_cb),
        .cr_i (in_cr),
        .dy_o (dy_q),
        .dcb_o(dcb_q),
        .dcr_o(dcr_q)
    );

    // Stage 2: constant products.
    logic signed [PROD_W-1:0] prod_q [NUM_PROD];

    ycc_mult_stage #(
        .OFS_W (OFS_W),
        .COEF_W(COEF_W),
        .COEFS (COEF_SET)
    ) u_mult (
        .clk   (clk),
        .dy_i  (dy_q),
        .dcb_i (dcb_q),
        .dcr_i (dcr_q),
        .prod_o(prod_q)
    );

    // Sign-extend products into accumulator width.
    logic signed [ACC_W-1:0] pw [NUM_PROD];
    generate
        for (genvar p = 0; p < NUM_PROD; p++) begin : g_ext
            assign pw[p] = {{(ACC_W-PROD_W){prod_q[p][PROD_W-1]}}, prod_q[p]};
        end
    endgenerate

    // Per-channel term sets: red, green, blue.
    logic signed [ACC_W-1:0] terms [NUM_CH][TERMS_PER];

    always_comb begin
        terms[0][0] = pw[P_Y];
        terms[0][1] = pw[P_RV];
        terms[0][2] = '0;
        terms[1][0] = pw[P_Y];
        terms[1][1] = -pw[P_GV];
        terms[1][2] = -pw[P_GU];
        terms[2][0] = pw[P_Y];
        terms[2][1] = pw[P_BU];
        terms[2][2] = '0;
    end

    // Stage 3: sum, shift, clamp, blank.
    logic [PIX_W-1:0] chan_pix [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            ycc_chan_out #(
                .ACC_W    (ACC_W),
                .FRAC_BITS(FRAC_BITS),
                .PIX_W    (PIX_W)
            ) u_chan (
                .clk    (clk),
                .rst    (rst),
                .term_i (terms[c]),
                .blank_i(flag_tap[LATENCY-2].blank),
                .pix_o  (chan_pix[c])
            );
        end
    endgenerate

    assign out_r     = chan_pix[0];
    assign out_g     = chan_pix[1];
    assign out_b     = chan_pix[2];
    assign out_valid = flag_tap[LATENCY-1].valid;
    assign out_hsync = flag_tap[LATENCY-1].hsync;
    assign out_vsync = flag_tap[LATENCY-1].vsync;
    assign out_blank = flag_tap[LATENCY-1].blank;

endmodule

// File: rtl/ycc2rgb_chk.sv
module ycc2rgb_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_hsync,
    input logic             in_vsync,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_r,
    input logic [PIX_W-1:0] out_g,
    input logic [PIX_W-1:0] out_b,
    input logic             out_hsync,
    input logic             out_vsync,
    input logic             out_blank
);

    // Edges seen with reset low, saturating at the pipeline depth.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_hsync_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_hsync == $past(in_hsync, 3)));

    assert_vsync_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_vsync == $past(in_vsync, 3)));

    assert_blank_black_R8: assert property (@(posedge clk) disable iff (rst)
        out_blank |-> (out_r == '0 && out_g == '0 && out_b == '0));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_hsync && !out_vsync && !out_blank));

endmodule

bind ycc2rgb_conv ycc2rgb_chk #(.PIX_W(PIX_W)) u_ycc2rgb_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_hsync (in_hsync),
    .in_vsync (in_vsync),
    .out_valid(out_valid),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b),
    .out_hsync(out_hsync),
    .out_vsync(out_vsync),
    .out_blank(out_blank)
);

// File: tb/test_ycc2rgb_conv.sv
`timescale 1ns/1ps
module test_ycc2rgb_conv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_y = 8'd0, in_cb = 8'd0, in_cr = 8'd0;
    logic       in_hsync = 1'b0, in_vsync = 1'b0, in_blank = 1'b0;
    logic       out_valid, out_hsync, out_vsync, out_blank;
    logic [7:0] out_r, out_g, out_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ycc2rgb_conv i_ycc2rgb_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .in_blank(in_blank),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_hsync(out_hsync), .out_vsync(out_vsync), .out_blank(out_blank)
    );

    // Vector: {valid, hsync, vsync, blank, y, cb, cr}
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {4'b1000, 8'd16,  8'd128, 8'd128},
        {4'b1000, 8'd235, 8'd128, 8'd128},
        {4'b1100, 8'd81,  8'd90,  8'd240},
        {4'b1000, 8'd145, 8'd54,  8'd34 },
        {4'b1010, 8'd41,  8'd240, 8'd110},
        {4'b0000, 8'd200, 8'd10,  8'd20 },
        {4'b1000, 8'd128, 8'd128, 8'd128},
        {4'b1001, 8'd200, 8'd100, 8'd200},
        {4'b1000, 8'd0,   8'd128, 8'd128},
        {4'b1000, 8'd255, 8'd128, 8'd128},
        {4'b1100, 8'd120, 8'd160, 8'd100},
        {4'b1000, 8'd60,  8'd100, 8'd150},
        {4'b1011, 8'd17,  8'd129, 8'd127},
        {4'b1000, 8'd235, 8'd255, 8'd255}
    };

    function automatic int clamp8(int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // ch: 0 red, 1 green, 2 blue
    function automatic int model(int y, int cb, int cr, int ch);
        int s;
        int dy = y - 16;
        int du = cb - 128;
        int dv = cr - 128;
        case (ch)
            0:       s = 1192*dy + 1634*dv;
            1:       s = 1192*dy - 833*dv - 401*du;
            default: s = 1192*dy + 2065*du;
        endcase
        return clamp8(s >>> 10);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic [27:0] v);
        in_valid = v[27];
        in_hsync = v[26];
        in_vsync = v[25];
        in_blank = v[24];
        in_y     = v[23:16];
        in_cb    = v[15:8];
        in_cr    = v[7:0];
    endtask

    task automatic check_vec(logic [27:0] v);
        check("R6 valid", int'(out_valid), int'(v[27]));
        check("R7 hsync", int'(out_hsync), int'(v[26]));
        check("R7 vsync", int'(out_vsync), int'(v[25]));
        if (v[27]) begin
            if (v[24]) begin
                check("R8 red",   int'(out_r), 0);
                check("R8 green", int'(out_g), 0);
                check("R8 blue",  int'(out_b), 0);
            end else begin
                check("R1 red",   int'(out_r), model(v[23:16], v[15:8], v[7:0], 0));
                check("R2 green", int'(out_g), model(v[23:16], v[15:8], v[7:0], 1));
                check("R3 blue",  int'(out_b), model(v[23:16], v[15:8], v[7:0], 2));
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 valid after reset", int'(out_valid), 0);
        check("R9 blank after reset", int'(out_blank), 0);
        check("R9 hsync after reset", int'(out_hsync), 0);
        rst = 1'b0;

        // R10: table streamed back to back
        for (int t = 0; t < NV + 3; t++) begin
            @(negedge clk);
            if (t >= 3) check_vec(VEC[t-3]);
            if (t < NV) drive(VEC[t]);
            else        drive(28'd0);
        end

        // R4: deep negative clamps to 0
        drive({4'b1000, 8'd0, 8'd128, 8'd128});
        @(negedge clk); drive(28'd0);
        @(negedge clk);
        @(negedge clk);
        check("R4 red",   int'(out_r), 0);
        check("R4 green", int'(out_g), 0);
        check("R4 blue",  int'(out_b), 0);

        // R5: overflow clamps to 255
        drive({4'b1000, 8'd255, 8'd128, 8'd128});
        @(negedge clk); drive(28'd0);
        @(negedge clk);
        @(negedge clk);
        check("R5 red",   int'(out_r), 255);
        check("R5 green", int'(out_g), 255);
        check("R5 blue",  int'(out_b), 255);

        // R9: reset with pixels in flight; none emerges afterwards
        drive({4'b1110, 8'd200, 8'd128, 8'd128});
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        drive(28'd0);
        @(negedge clk);
        check("R9 valid at flush", int'(out_valid), 0);
        check("R9 hsync at flush", int'(out_hsync), 0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 no leftover pixel", int'(out_valid), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule